// File: doc/BRIEF.md
# Frame Alignment Change Monitor

This monitor sits next to a frame synchronizer and watches what the synchronizer reports. It does not search for frames or compute CRCs. The synchronizer gives it three things: a strobe when lock is gained, together with the bit position of the new alignment; a strobe when lock is lost; and one CRC verdict strobe per superframe.

The monitor produces two single-cycle event pulses for a latched status register that sits downstream.

- **Change-of-alignment pulse.** The monitor keeps the position of the most recent lock. It pulses only when lock is regained at a position different from that one. There is no pulse on the very first lock after reset, because no earlier position exists to compare against.
- **False-alignment pulse.** The monitor counts superframes whose CRC fails back to back while locked. It pulses when the run reaches the configured length, which defaults to 32. The count then starts over, so a lock that stays bad keeps producing pulses at that spacing.

Both pulses are registered. Each appears in the cycle after the input strobe that causes it.

Top module: `falign_mon`

## Requirements
- R1: After reset, `locked`, `cofa_evt` and `ffa_evt` are 0. The memory that records whether lock has ever been held is cleared only by reset.
- R2: The first lock strobe after reset sets `locked` in the next cycle and produces no `cofa_evt`. This holds whatever position the lock reports.
- R3: A lock strobe taken while unlocked, after an earlier lock, raises `cofa_evt` for exactly one cycle in the next cycle when `acq_pos` differs from the stored position. The new position is then stored.
- R4: A lock strobe taken while unlocked at the stored position produces no `cofa_evt`.
- R5: A lock strobe that arrives while `locked` is 1 is ignored. It produces no pulse and leaves the stored position unchanged.
- R6: A loss strobe clears `locked` in the next cycle. When loss and lock strobes arrive in the same cycle, the loss wins and the lock strobe is ignored.
- R7: While locked, the `crc_stb` strobe that completes RUN_LEN (default 32) consecutive strobes with `crc_bad`=1 raises `ffa_evt` for one cycle, in the next cycle.
- R8: A `crc_stb` with `crc_bad`=0 resets the run to zero. Cycles without `crc_stb` leave the run as it is.
- R9: After a `ffa_evt`, the run restarts at zero. Each further RUN_LEN consecutive bad superframes produce another `ffa_evt`.
- R10: While unlocked, the run is held at zero and CRC strobes are ignored. A new lock therefore starts counting from zero.
- R11: A loss strobe that arrives in the same cycle as the bad superframe that would complete a run suppresses `ffa_evt` and clears the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_stb | input | 1 | Synchronizer reports lock gained |
| loss_stb | input | 1 | Synchronizer reports lock lost |
| acq_pos | input | POS_W | Bit position of the alignment, valid with `acq_stb` |
| crc_stb | input | 1 | One strobe per received superframe |
| crc_bad | input | 1 | CRC failed for this superframe, valid with `crc_stb` |
| locked | output | 1 | Monitor's view of the lock state |
| cofa_evt | output | 1 | Single-cycle change-of-alignment pulse |
| ffa_evt | output | 1 | Single-cycle false-alignment pulse |

## Verification
Two functions can meet in the same cycle. The first is the lock-loss handling. The second is the completion of a bad-CRC run.

The bench builds a run of RUN_LEN-1 bad superframes. It then presents the final bad strobe in the same cycle as a loss strobe. It expects no `ffa_evt`, a cleared `locked`, and a run that restarts from zero after relocking.

A second collision puts a lock strobe and a loss strobe in one cycle, using a new position. The bench expects the lock to be ignored. It confirms this by relocking at the old position and seeing no change-of-alignment pulse.

// File: rtl/falign_mon.sv
module falign_mon #(
  parameter int POS_W   = 8,
  parameter int RUN_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_stb,
  input  logic             loss_stb,
  input  logic [POS_W-1:0] acq_pos,
  input  logic             crc_stb,
  input  logic             crc_bad,
  output logic             locked,
  output logic             cofa_evt,
  output logic             ffa_evt
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic             ever;
  logic [POS_W-1:0] held;
  logic [CW-1:0]    run;
  logic             take;
  logic             moved;
  logic             hit;
  logic             run_end;

  assign take    = acq_stb & ~loss_stb & ~locked;
  assign moved   = ever & (acq_pos != held);
  assign hit     = locked & ~loss_stb & crc_stb & crc_bad;
  assign run_end = (run == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      ever     <= 1'b0;
      held     <= '0;
      run      <= '0;
      cofa_evt <= 1'b0;
      ffa_evt  <= 1'b0;
    end else begin
      cofa_evt <= take & moved;
      ffa_evt  <= hit & run_end;
      if (loss_stb)  locked <= 1'b0;
      else if (take) locked <= 1'b1;
      if (take) begin
        ever <= 1'b1;
        held <= acq_pos;
      end
      if (!locked || loss_stb)      run <= '0;
      else if (crc_stb) begin
        if (!crc_bad || run_end)    run <= '0;
        else                        run <= run + 1'b1;
      end
    end
  end
endmodule

module falign_mon_chk #(
  parameter int POS_W   = 8,
  parameter int RUN_LEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_stb,
  input logic             loss_stb,
  input logic [POS_W-1:0] acq_pos,
  input logic             crc_stb,
  input logic             crc_bad,
  input logic             locked,
  input logic             cofa_evt,
  input logic             ffa_evt
);
  // R3
  cofa_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cofa_evt |-> $past(acq_stb && !loss_stb && !locked));
  // R7
  ffa_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffa_evt |-> $past(locked && crc_stb && crc_bad && !loss_stb));
  // R6
  loss_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_stb |=> !locked);
  // R2
  acq_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_stb && !loss_stb) |=> locked);
  // R5
  locked_no_cofa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && acq_stb) |=> !cofa_evt);
  // R9
  ffa_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffa_evt |=> !ffa_evt);
  // R10
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cofa_evt && ffa_evt));
endmodule

bind falign_mon falign_mon_chk #(.POS_W(POS_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_stb(acq_stb), .loss_stb(loss_stb),
  .acq_pos(acq_pos), .crc_stb(crc_stb), .crc_bad(crc_bad),
  .locked(locked), .cofa_evt(cofa_evt), .ffa_evt(ffa_evt));

// File: tb/falign_mon_bench.sv
module falign_mon_bench;
  localparam int PW = 3;
  localparam int RL = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic acq_stb, loss_stb, crc_stb, crc_bad;
  logic [PW-1:0] acq_pos;
  logic locked, cofa_evt, ffa_evt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  falign_mon #(.POS_W(PW), .RUN_LEN(RL)) u_falign_mon (
    .clk(clk), .rst_n(rst_n), .acq_stb(acq_stb), .loss_stb(loss_stb),
    .acq_pos(acq_pos), .crc_stb(crc_stb), .crc_bad(crc_bad),
    .locked(locked), .cofa_evt(cofa_evt), .ffa_evt(ffa_evt));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic a, logic l, logic [PW-1:0] p, logic cs, logic cb);
    acq_stb = a; loss_stb = l; acq_pos = p; crc_stb = cs; crc_bad = cb;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic bad_run(int n, string tag);
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b1);
      chk(tag, ffa_evt, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] hp;
    rst_n = 1'b0;
    acq_stb = 0; loss_stb = 0; acq_pos = '0; crc_stb = 0; crc_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 locked", locked, 1'b0);
    chk("R1 cofa", cofa_evt, 1'b0);
    chk("R1 ffa", ffa_evt, 1'b0);

    // R2: first lock after reset, any position
    step(1'b1, 1'b0, 3'd5, 1'b0, 1'b0);
    chk("R2 first lock no cofa", cofa_evt, 1'b0);
    chk("R2 locked", locked, 1'b1);
    hp = 3'd5;

    // R3/R4 sweep over all position pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b0, 1'b1, '0, 1'b0, 1'b0);
        chk("R6 unlock", locked, 1'b0);
        step(1'b1, 1'b0, PW'(a), 1'b0, 1'b0);
        chk((PW'(a) != hp) ? "R3 move" : "R4 same", cofa_evt, PW'(a) != hp);
        hp = PW'(a);
        idle();
        chk("R3 one cycle", cofa_evt, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0, 1'b0);
        step(1'b1, 1'b0, PW'(b), 1'b0, 1'b0);
        chk((a != b) ? "R3 move" : "R4 same", cofa_evt, a != b);
        hp = PW'(b);
        // R5: lock strobe while locked, at another position
        step(1'b1, 1'b0, PW'(b + 3), 1'b0, 1'b0);
        chk("R5 ignored while locked", cofa_evt, 1'b0);
      end
    end
    // R5: stored position unchanged, relock at hp gives no pulse
    step(1'b0, 1'b1, '0, 1'b0, 1'b0);
    step(1'b1, 1'b0, hp, 1'b0, 1'b0);
    chk("R5 held kept", cofa_evt, 1'b0);

    // R6: simultaneous loss and lock, lock ignored
    step(1'b1, 1'b1, hp + 3'd1, 1'b0, 1'b0);
    chk("R6 loss wins", locked, 1'b0);
    chk("R6 no cofa", cofa_evt, 1'b0);
    step(1'b1, 1'b0, hp, 1'b0, 1'b0);
    chk("R6 held unchanged", cofa_evt, 1'b0);

    // R7/R9: continuous bad CRC, pulses every RL with idle gaps
    for (int k = 1; k <= 3 * RL; k++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b1);
      chk((k > RL) ? "R9 repeat" : "R7 run", ffa_evt, (k % RL) == 0);
      if (k % 5 == 0) begin
        step(1'b0, 1'b0, '0, 1'b0, 1'b1);
        chk("R8 no strobe holds", ffa_evt, 1'b0);
      end
    end

    // R8: good CRC restarts run
    bad_run(RL - 1, "R8 pre");
    step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    chk("R8 good", ffa_evt, 1'b0);
    bad_run(RL - 1, "R8 after good");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1);
    chk("R8 full run", ffa_evt, 1'b1);

    // R10: unlocked strobes ignored, run cleared by unlock
    bad_run(RL - 2, "R10 partial");
    step(1'b0, 1'b1, '0, 1'b0, 1'b0);
    bad_run(RL + 5, "R10 unlocked");
    step(1'b1, 1'b0, hp, 1'b0, 1'b0);
    bad_run(RL - 1, "R10 relock");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1);
    chk("R10 run from zero", ffa_evt, 1'b1);

    // R11: loss on the completing bad superframe
    bad_run(RL - 1, "R11 pre");
    step(1'b0, 1'b1, '0, 1'b1, 1'b1);
    chk("R11 suppressed", ffa_evt, 1'b0);
    chk("R11 unlocked", locked, 1'b0);
    step(1'b1, 1'b0, hp, 1'b0, 1'b0);
    bad_run(RL - 1, "R11 cleared");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1);
    chk("R11 fresh run", ffa_evt, 1'b1);

    // R1/R2: reset forgets history; different position gives no pulse
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    chk("R1 locked after reset", locked, 1'b0);
    step(1'b1, 1'b0, hp + 3'd2, 1'b0, 1'b0);
    chk("R2 first lock after reset", cofa_evt, 1'b0);
    chk("R2 locked again", locked, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule